// File: doc/BRIEF.md
# Contiguous-Run Unit Allocator

This block keeps a pool of equal-sized allocation units, with one status bit for each unit: 1 means the unit is in use and 0 means it is free. A client sends allocate or release operations one at a time. For an allocation, the block scans its status map serially, one unit per clock, for a run of free units long enough to hold the requested length. It then marks that run as used and returns the index of its first unit. For a release, the client gives a first unit and a length. The block checks that every unit in that range is currently in use, then clears those bits. Free neighbours therefore join into one larger hole with no further work.

Each allocation picks one of three placement policies. Lowest-address placement takes the first hole that fits. Rotating placement starts at a roving pointer and wraps around the pool. Tightest placement looks at every hole and picks the smallest one that fits. A response reports one of three outcomes: success, "no hole large enough", or a request error. The block accepts a new operation only after it has issued the response to the previous one.

Top module: `unit_pool_alloc`

## Requirements
- R1: After reset every unit is free, the roving pointer is 0, `req_ready` is 1 and `resp_valid` is 0.
- R2: An operation is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` stays 0 until the response has been given. The response is a single-cycle pulse on `resp_valid`, and `req_ready` is 1 again in the cycle after it.
- R3: A request whose length is 0 or greater than UNITS, or a release whose range `req_start + req_len` exceeds UNITS, gives `resp_err`=1 and `resp_ok`=0 one cycle after acceptance, and changes neither the map nor the pointer.
- R4: With `req_policy` 0 (lowest-address), and likewise with the spare code 3, the block allocates at the lowest index s for which units s to s+len-1 are all free.
- R5: With `req_policy` 1 (rotating), the candidate starts are tried in circular order from the roving pointer, and the first start whose window is free and lies wholly inside the pool is chosen. A run never continues from the last unit to unit 0.
- R6: With `req_policy` 2 (tightest), the block chooses the shortest maximal free run whose length is at least `req_len`, allocates at that run's first unit, and breaks a tie in favour of the lowest index.
- R7: A successful allocation gives `resp_ok`=1, `resp_err`=0 and `resp_start`= the chosen index, and marks all `req_len` units from that index as used.
- R8: When no suitable hole exists, the response is `resp_ok`=0, `resp_err`=0 and `resp_start`=0, and the map is left unchanged.
- R9: A release (`req_op`=1) of a range whose units are all in use clears them and gives `resp_ok`=1 with `resp_start` echoing the start. Released ranges that touch other free units form one hole.
- R10: A release that covers any unit that is already free gives `resp_err`=1 and leaves the whole map unchanged.
- R11: After each successful allocation, under any policy, the roving pointer becomes (start + len) mod UNITS. Releases, failures and errors leave it where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_policy | input | 2 | Placement: 0 lowest, 1 rotating, 2 tightest, 3 as lowest |
| req_start | input | $clog2(UNITS) | First unit of a release |
| req_len | input | $clog2(UNITS+1) | Number of units |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_ok | output | 1 | Operation succeeded |
| resp_err | output | 1 | Malformed length or range, or release of a free unit |
| resp_start | output | $clog2(UNITS) | Allocated or released first unit; 0 unless ok |

## Verification
Each policy is tried on maps built to hold holes of unequal sizes, so that lowest-address, rotating and tightest placement give different answers for the same length. Pairs of equal-size holes show whether the tie goes to the lowest index. A hole that touches the top of the pool, with the pointer close to the end, shows whether a run wrongly continues across the wrap point. Released neighbours followed by a long request show that merging works. A long pseudo-random mix of operations under all policies is compared against a bench reference map, so that corrupted bits or a stale pointer show up in later answers.

// File: rtl/upa_pkg.sv
package upa_pkg;

  typedef enum logic [1:0] {
    POL_LOWEST  = 2'd0,
    POL_ROTATE  = 2'd1,
    POL_TIGHT   = 2'd2,
    POL_SPARE   = 2'd3
  } pol_e;

  typedef enum logic {
    OP_ALLOC   = 1'b0,
    OP_RELEASE = 1'b1
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_SCAN  = 2'd2,
    ST_RESP  = 2'd3
  } fsm_e;

endpackage

// File: rtl/upa_rst_sync.sv
module upa_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/upa_span_mask.sv
module upa_span_mask #(
  parameter int UNITS = 64,
  localparam int IDX_W = $clog2(UNITS),
  localparam int LEN_W = $clog2(UNITS + 1),
  localparam int SUM_W = LEN_W + 1
) (
  input  logic [IDX_W-1:0] base_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [UNITS-1:0] mask_o
);

  logic [SUM_W-1:0] lo;
  logic [SUM_W-1:0] hi;

  assign lo = SUM_W'(base_i);
  assign hi = SUM_W'(base_i) + SUM_W'(len_i);

  for (genvar gi = 0; gi < UNITS; gi++) begin : g_bit
    localparam logic [SUM_W-1:0] POS = SUM_W'(gi);
    assign mask_o[gi] = (POS >= lo) && (POS < hi);
  end

endmodule

// File: rtl/upa_bitmap.sv
module upa_bitmap #(
  parameter int UNITS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [UNITS-1:0] mask_i,
  output logic [UNITS-1:0] map_o
);

  logic [UNITS-1:0] map_q;
  logic [UNITS-1:0] map_d;
  logic             map_en;

  always_comb begin
    map_en = set_i || clr_i;
    map_d  = map_q;
    if (set_i) begin
      map_d = map_q | mask_i;
    end else if (clr_i) begin
      map_d = map_q & ~mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
    end else if (map_en) begin
      map_q <= map_d;
    end
  end

  assign map_o = map_q;

endmodule

// File: rtl/upa_hole_scan.sv
module upa_hole_scan
  import upa_pkg::*;
#(
  parameter int UNITS = 64,
  localparam int IDX_W = $clog2(UNITS),
  localparam int LEN_W = $clog2(UNITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  pol_e             pol_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [IDX_W-1:0] ptr_i,
  input  logic [UNITS-1:0] map_i,
  output logic             fin_o,
  output logic             fin_ok_o,
  output logic [IDX_W-1:0] fin_start_o
);

  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(UNITS - 1);

  logic             busy_q,      busy_d;
  logic             last_q,      last_d;
  pol_e             pol_q,       pol_d;
  logic [LEN_W-1:0] len_q,       len_d;
  logic [IDX_W-1:0] pos_q,       pos_d;
  logic [LEN_W-1:0] run_len_q,   run_len_d;
  logic [IDX_W-1:0] run_start_q, run_start_d;
  logic             best_vld_q,  best_vld_d;
  logic [LEN_W-1:0] best_len_q,  best_len_d;
  logic [IDX_W-1:0] best_st_q,   best_st_d;
  logic             state_en;

  logic             unit_free;
  logic [LEN_W-1:0] ext_len;
  logic [IDX_W-1:0] ext_start;
  logic             at_end;
  logic             tight;
  logic             hit_lin;
  logic             closes;
  logic [LEN_W-1:0] hole_len;
  logic [IDX_W-1:0] hole_start;
  logic             cand;

  // Per-unit run tracking
  always_comb begin
    unit_free  = ~map_i[pos_q];
    ext_len    = unit_free ? (run_len_q + 1'b1) : '0;
    ext_start  = (unit_free && (run_len_q == '0)) ? pos_q : run_start_q;
    at_end     = (pos_q == LAST_POS);
    tight      = (pol_q == POL_TIGHT);
    hit_lin    = !tight && unit_free && (ext_len == len_q);
    closes     = !unit_free || at_end;
    hole_len   = unit_free ? ext_len : run_len_q;
    hole_start = unit_free ? ext_start : run_start_q;
    cand       = tight && closes && (hole_len >= len_q)
                 && (!best_vld_q || (hole_len < best_len_q));
  end

  // Completion outputs
  always_comb begin
    fin_o       = busy_q && (hit_lin || (at_end && (tight || last_q)));
    fin_ok_o    = tight ? (best_vld_q || cand) : hit_lin;
    fin_start_o = tight ? (cand ? hole_start : best_st_q) : ext_start;
  end

  // Next-state
  always_comb begin
    busy_d      = busy_q;
    last_d      = last_q;
    pol_d       = pol_q;
    len_d       = len_q;
    pos_d       = pos_q;
    run_len_d   = run_len_q;
    run_start_d = run_start_q;
    best_vld_d  = best_vld_q;
    best_len_d  = best_len_q;
    best_st_d   = best_st_q;
    state_en    = 1'b0;
    if (start_i) begin
      state_en    = 1'b1;
      busy_d      = 1'b1;
      pol_d       = pol_i;
      len_d       = len_i;
      pos_d       = (pol_i == POL_ROTATE) ? ptr_i : '0;
      last_d      = (pol_i != POL_ROTATE) || (ptr_i == '0);
      run_len_d   = '0;
      run_start_d = '0;
      best_vld_d  = 1'b0;
      best_len_d  = '0;
      best_st_d   = '0;
    end else if (busy_q) begin
      state_en = 1'b1;
      if (fin_o) begin
        busy_d = 1'b0;
      end else if (at_end) begin
        // rotating policy: second pass from unit 0, run broken at wrap
        pos_d     = '0;
        last_d    = 1'b1;
        run_len_d = '0;
      end else begin
        pos_d       = pos_q + 1'b1;
        run_len_d   = ext_len;
        run_start_d = ext_start;
        if (cand) begin
          best_vld_d = 1'b1;
          best_len_d = hole_len;
          best_st_d  = hole_start;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      last_q      <= 1'b0;
      pol_q       <= POL_LOWEST;
      len_q       <= '0;
      pos_q       <= '0;
      run_len_q   <= '0;
      run_start_q <= '0;
      best_vld_q  <= 1'b0;
      best_len_q  <= '0;
      best_st_q   <= '0;
    end else if (state_en) begin
      busy_q      <= busy_d;
      last_q      <= last_d;
      pol_q       <= pol_d;
      len_q       <= len_d;
      pos_q       <= pos_d;
      run_len_q   <= run_len_d;
      run_start_q <= run_start_d;
      best_vld_q  <= best_vld_d;
      best_len_q  <= best_len_d;
      best_st_q   <= best_st_d;
    end
  end

endmodule

// File: rtl/unit_pool_alloc.sv
module unit_pool_alloc
  import upa_pkg::*;
#(
  parameter int UNITS = 64,
  localparam int IDX_W = $clog2(UNITS),
  localparam int LEN_W = $clog2(UNITS + 1),
  localparam int SUM_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic [1:0]       req_policy,
  input  logic [IDX_W-1:0] req_start,
  input  logic [LEN_W-1:0] req_len,
  output logic             resp_valid,
  output logic             resp_ok,
  output logic             resp_err,
  output logic [IDX_W-1:0] resp_start
);

  localparam logic [SUM_W-1:0] POOL = SUM_W'(UNITS);

  logic             rst_int_n;
  fsm_e             st_q,    st_d;
  op_e              op_q,    op_d;
  logic [LEN_W-1:0] len_q,   len_d;
  logic [IDX_W-1:0] start_q, start_d;
  logic             ok_q,    ok_d;
  logic             err_q,   err_d;
  logic [IDX_W-1:0] ptr_q,   ptr_d;
  logic             ptr_en;

  logic             accept;
  logic [SUM_W-1:0] req_end;
  logic             req_bad;
  logic             scan_go;
  logic             scan_fin;
  logic             scan_ok;
  logic [IDX_W-1:0] scan_start;
  logic [UNITS-1:0] map;
  logic [UNITS-1:0] span;
  logic             span_used;
  logic             map_set;
  logic             map_clr;
  logic [SUM_W-1:0] run_end;

  upa_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  upa_span_mask #(.UNITS(UNITS)) u_span (
    .base_i (start_q),
    .len_i  (len_q),
    .mask_o (span)
  );

  upa_bitmap #(.UNITS(UNITS)) u_map (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (map_set),
    .clr_i  (map_clr),
    .mask_i (span),
    .map_o  (map)
  );

  upa_hole_scan #(.UNITS(UNITS)) u_scan (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (scan_go),
    .pol_i       (pol_e'(req_policy)),
    .len_i       (req_len),
    .ptr_i       (ptr_q),
    .map_i       (map),
    .fin_o       (scan_fin),
    .fin_ok_o    (scan_ok),
    .fin_start_o (scan_start)
  );

  // Request qualification
  always_comb begin
    accept    = req_valid && (st_q == ST_IDLE);
    req_end   = SUM_W'(req_start) + SUM_W'(req_len);
    req_bad   = (req_len == '0) || (SUM_W'(req_len) > POOL)
                || (req_op && (req_end > POOL));
    scan_go   = accept && !req_bad && (req_op == OP_ALLOC);
    span_used = ((map & span) == span);
  end

  // Control next-state
  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    len_d   = len_q;
    start_d = start_q;
    ok_d    = ok_q;
    err_d   = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          op_d    = op_e'(req_op);
          len_d   = req_len;
          start_d = req_start;
          ok_d    = 1'b0;
          err_d   = req_bad;
          if (req_bad) begin
            st_d = ST_RESP;
          end else if (req_op == OP_RELEASE) begin
            st_d = ST_CHECK;
          end else begin
            st_d = ST_SCAN;
          end
        end
      end
      ST_CHECK: begin
        ok_d  = span_used;
        err_d = !span_used;
        st_d  = ST_RESP;
      end
      ST_SCAN: begin
        if (scan_fin) begin
          ok_d    = scan_ok;
          start_d = scan_start;
          st_d    = ST_RESP;
        end
      end
      ST_RESP: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Commit on the response cycle
  always_comb begin
    map_set = (st_q == ST_RESP) && ok_q && (op_q == OP_ALLOC);
    map_clr = (st_q == ST_RESP) && ok_q && (op_q == OP_RELEASE);
    ptr_en  = map_set;
    run_end = SUM_W'(start_q) + SUM_W'(len_q);
    ptr_d   = (run_end >= POOL) ? '0 : IDX_W'(run_end);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_ALLOC;
      len_q   <= '0;
      start_q <= '0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      len_q   <= len_d;
      start_q <= start_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign resp_valid = (st_q == ST_RESP);
  assign resp_ok    = ok_q;
  assign resp_err   = err_q;
  assign resp_start = ok_q ? start_q : '0;

endmodule

// File: rtl/upa_chk.sv
module upa_chk #(
  parameter int UNITS = 64,
  localparam int IDX_W = $clog2(UNITS),
  localparam int LEN_W = $clog2(UNITS + 1),
  localparam int SUM_W = LEN_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_op,
  input logic [IDX_W-1:0] req_start,
  input logic [LEN_W-1:0] req_len,
  input logic             resp_valid,
  input logic             resp_ok,
  input logic             resp_err,
  input logic [IDX_W-1:0] resp_start
);

  logic             rec_op;
  logic [IDX_W-1:0] rec_start;
  logic [LEN_W-1:0] rec_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_op    <= 1'b0;
      rec_start <= '0;
      rec_len   <= '0;
    end else if (req_valid && req_ready) begin
      rec_op    <= req_op;
      rec_start <= req_start;
      rec_len   <= req_len;
    end
  end

  AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);  // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);  // R2
  AST_NOT_READY_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);  // R2
  AST_BAD_LEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ((req_len == '0) || (SUM_W'(req_len) > SUM_W'(UNITS))))
      |=> (resp_valid && resp_err && !resp_ok));  // R3
  AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_ok && resp_err));  // R8
  AST_FAIL_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ok) |-> (resp_start == '0));  // R8
  AST_RUN_IN_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ok && !rec_op)
      |-> ((SUM_W'(resp_start) + SUM_W'(rec_len)) <= SUM_W'(UNITS)));  // R7
  AST_RELEASE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ok && rec_op) |-> (resp_start == rec_start));  // R9

endmodule

bind unit_pool_alloc upa_chk #(.UNITS(UNITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .req_start  (req_start),
  .req_len    (req_len),
  .resp_valid (resp_valid),
  .resp_ok    (resp_ok),
  .resp_err   (resp_err),
  .resp_start (resp_start)
);

// File: tb/tb_unit_pool_alloc.sv
module tb_unit_pool_alloc;

  localparam int CLK_PERIOD = 10;
  localparam int UNITS = 64;
  localparam int IDX_W = $clog2(UNITS);
  localparam int LEN_W = $clog2(UNITS + 1);

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic             req_op;
  logic [1:0]       req_policy;
  logic [IDX_W-1:0] req_start;
  logic [LEN_W-1:0] req_len;
  logic             resp_valid;
  logic             resp_ok;
  logic             resp_err;
  logic [IDX_W-1:0] resp_start;

  int n_checks = 0;
  int n_errors = 0;
  logic [UNITS-1:0] mdl;
  int mptr;
  logic [31:0] lfsr;

  unit_pool_alloc #(.UNITS(UNITS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_policy(req_policy), .req_start(req_start),
    .req_len(req_len), .resp_valid(resp_valid), .resp_ok(resp_ok),
    .resp_err(resp_err), .resp_start(resp_start)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit win_free(input logic [UNITS-1:0] m, input int s, input int len);
    if (s + len > UNITS) return 0;
    for (int k = s; k < s + len; k++) if (m[k]) return 0;
    return 1;
  endfunction

  function automatic int ref_lowest(input logic [UNITS-1:0] m, input int len);
    for (int s = 0; s < UNITS; s++) if (win_free(m, s, len)) return s;
    return -1;
  endfunction

  function automatic int ref_rotate(input logic [UNITS-1:0] m, input int len, input int p);
    for (int k = 0; k < UNITS; k++) if (win_free(m, (p + k) % UNITS, len)) return (p + k) % UNITS;
    return -1;
  endfunction

  function automatic int ref_tight(input logic [UNITS-1:0] m, input int len);
    int i = 0;
    int best = -1;
    int bl = UNITS + 1;
    while (i < UNITS) begin
      if (m[i]) i++;
      else begin
        int j = i;
        while (j < UNITS && !m[j]) j++;
        if ((j - i) >= len && (j - i) < bl) begin best = i; bl = j - i; end
        i = j;
      end
    end
    return best;
  endfunction

  task automatic do_op(input bit op, input int pol, input int st, input int len,
                       output bit ok, output bit er, output int rs, output bit hung);
    int w = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_policy = pol[1:0];
    req_start = st[IDX_W-1:0]; req_len = len[LEN_W-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && w < 1000) begin @(negedge clk); w++; end
    hung = (w >= 1000);
    ok = resp_ok; er = resp_err; rs = int'(resp_start);
  endtask

  // Runs one operation, predicts it from the reference map, checks it.
  task automatic exec(input bit op, input int pol, input int st, input int len, input string tag_in);
    bit ok, er, hung, bad, e_ok, e_err;
    int rs, s;
    string tag;
    s = -1;
    bad = (len == 0) || (len > UNITS) || (op && (st + len > UNITS));
    if (bad) begin
      e_ok = 0; e_err = 1; tag = "R3";
    end else if (op) begin
      e_ok = 1;
      for (int k = st; k < st + len; k++) if (!mdl[k]) e_ok = 0;
      e_err = !e_ok; tag = e_ok ? "R9" : "R10";
    end else begin
      if (pol == 1) begin s = ref_rotate(mdl, len, mptr); tag = "R5"; end
      else if (pol == 2) begin s = ref_tight(mdl, len); tag = "R6"; end
      else begin s = ref_lowest(mdl, len); tag = "R4"; end
      e_ok = (s >= 0); e_err = 0;
      if (!e_ok) tag = "R8";
    end
    if (tag_in != "") tag = tag_in;
    do_op(op, pol, st, len, ok, er, rs, hung);
    check(tag, "response arrived", hung, 0);
    check(tag, "resp_ok", ok, e_ok);
    check(tag, "resp_err", er, e_err);
    if (e_ok && !op) check(tag, "resp_start", rs, s);
    else if (e_ok) check(tag, "resp_start echo", rs, st);
    else check(tag, "resp_start zero", rs, 0);
    if (e_ok && !op) begin
      for (int k = s; k < s + len; k++) mdl[k] = 1'b1;
      mptr = (s + len) % UNITS;
    end else if (e_ok) begin
      for (int k = st; k < st + len; k++) mdl[k] = 1'b0;
    end
  endtask

  task automatic clear_all();
    int i = 0;
    while (i < UNITS) begin
      if (!mdl[i]) i++;
      else begin
        int j = i;
        while (j < UNITS && mdl[j]) j++;
        exec(1, 0, i, j - i, "R9");
        i = j;
      end
    end
  endtask

  task automatic t_reset();
    check("R1", "req_ready after reset", req_ready, 1);
    check("R1", "resp_valid after reset", resp_valid, 0);
    exec(0, 1, 0, 1, "R1");   // rotating from pointer 0 on an empty pool lands at 0
    exec(1, 0, 0, 1, "R9");
  endtask

  task automatic t_handshake();
    int w = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 1'b0; req_policy = 2'd2; req_start = '0; req_len = 7'd5;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "req_ready low while busy", req_ready, 0);
    check("R2", "no early response", resp_valid, 0);
    while (!resp_valid && w < 1000) begin @(negedge clk); w++; end
    check("R2", "resp_ok", resp_ok, 1);
    check("R7", "resp_start on empty pool", resp_start, 0);
    @(negedge clk);
    check("R2", "resp_valid single cycle", resp_valid, 0);
    check("R2", "req_ready back", req_ready, 1);
    for (int k = 0; k < 5; k++) mdl[k] = 1'b1;
    mptr = 5;
  endtask

  task automatic t_lowest();
    clear_all();
    exec(0, 0, 0, 3, "");
    exec(0, 0, 0, 5, "");
    exec(0, 0, 0, 2, "");
    exec(1, 0, 3, 5, "");
    exec(0, 0, 0, 4, "R7");   // lands at 3
    exec(0, 3, 0, 1, "R4");   // spare code behaves as lowest-address
    exec(0, 0, 0, 3, "");
    exec(1, 0, 3, 4, "R7");   // range marked used by the earlier allocation
  endtask

  task automatic t_tight();
    clear_all();
    exec(0, 0, 0, 20, "");
    exec(1, 0, 2, 5, "");
    exec(1, 0, 9, 3, "");
    exec(1, 0, 14, 3, "");
    exec(0, 2, 0, 3, "R6");   // tie between 9 and 14
    exec(0, 2, 0, 4, "R6");   // hole at 2
    exec(0, 2, 0, 6, "R6");   // only the top region
  endtask

  task automatic t_rotate();
    clear_all();
    exec(0, 0, 0, 60, "");
    exec(1, 0, 0, 60, "");
    exec(0, 1, 0, 8, "R5");   // pointer 60, no wrap-spanning run
    exec(0, 1, 0, 2, "R11");
    exec(1, 0, 0, 8, "");     // release leaves pointer
    exec(0, 1, 0, 3, "R11");
    exec(0, 2, 0, 4, "R11");  // tightest also moves pointer
    exec(0, 1, 0, 1, "R11");
  endtask

  task automatic t_errors();
    clear_all();
    exec(0, 0, 0, 10, "");
    exec(0, 0, 0, 0, "R3");
    exec(0, 2, 0, 65, "R3");
    exec(1, 0, 60, 8, "R3");
    exec(1, 0, 8, 4, "R10");  // 10, 11 already free
    exec(1, 0, 0, 10, "R10"); // map intact: whole range still in use
    exec(0, 1, 0, 1, "R11");  // pointer untouched by errors
  endtask

  task automatic t_nofit();
    clear_all();
    exec(0, 0, 0, 64, "");
    exec(0, 0, 0, 1, "R8");
    exec(1, 0, 10, 4, "");
    exec(0, 2, 0, 5, "R8");
    exec(0, 1, 0, 5, "R8");
    exec(0, 0, 0, 4, "R8");   // hole still there after failures
  endtask

  task automatic t_merge();
    clear_all();
    exec(0, 0, 0, 12, "");
    exec(1, 0, 0, 4, "R9");
    exec(1, 0, 4, 4, "R9");
    exec(0, 0, 0, 8, "R9");
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] < 6) exec(1, 0, int'(lfsr[13:8]), 1 + int'(lfsr[18:16]), "");
      else exec(0, int'(lfsr[21:20]), 0, 1 + int'(lfsr[27:24]) % 12, "");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0; req_policy = 2'd0;
    req_start = '0; req_len = '0;
    mdl = '0; mptr = 0; lfsr = 32'h1d2c_3b4a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_handshake();
    t_lowest();
    t_tight();
    t_rotate();
    t_errors();
    t_nofit();
    t_merge();
    t_random();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule